// File: doc/BRIEF.md
# Program-flow checkpoint kick gate

This block sits between a processor and its watchdog timer and only lets a watchdog service pulse through when the software's main loop has demonstrably walked through every required checkpoint in order. Software writes short command codes to a single write port. Each code either loads a starting value into an internal 16-bit running signature or advances it by a fixed offset. Two of the codes also check the signature before advancing it.

The sequence one loop pass must produce is: load the start value 16'h5555, pass the entry checkpoint (which demands 16'h5555 and adds 16'h1111), apply the body offset (adds 16'h2222), then request the kick. The kick request succeeds only when the signature reads 16'h8888. On success, one single-cycle pulse goes to the downstream watchdog and the signature returns to zero. Code that crashes and jumps straight to the kick request finds a wrong signature and trips a sticky fault output instead. That fault output is meant to halt or reset the system. The current signature is always visible for debug.

Top module: `ckg_top`

## Requirements
- R1: While and after reset, sig_o is 16'h0000 and both kick_o and fault_o are low.
- R2: A write of code 4'h1 (seed load) sets sig_o to 16'h5555 from the clock edge that takes the write.
- R3: A write of code 4'h2 (entry checkpoint) adds 16'h1111 to the signature when it reads 16'h5555. Otherwise it raises fault_o and leaves the signature unchanged.
- R4: A write of code 4'h3 (body offset) adds 16'h2222 to the signature, modulo 2^16, with no check.
- R5: A write of code 4'h4 (kick request) when the signature reads 16'h8888 drives kick_o high for exactly the one cycle after the write edge and clears the signature to 16'h0000.
- R6: A write of code 4'h4 when the signature is not 16'h8888 raises fault_o, gives no kick and leaves the signature unchanged.
- R7: A write of any code other than 4'h1, 4'h2, 4'h3 or 4'h4 raises fault_o and leaves the signature unchanged.
- R8: fault_o stays high until reset. While it is high, no kick is forwarded and writes leave sig_o unchanged.
- R9: Cycles with wr_en_i low change neither sig_o nor fault_o and give no kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the command code |
| wr_code_i | input | 4 | Command code |
| kick_o | output | 1 | One-cycle watchdog service pulse |
| fault_o | output | 1 | Sticky sequence fault, halt request |
| sig_o | output | 16 | Current running signature |

## Verification
The assertions assume that a write lasts exactly one cycle per command and that wr_code_i is a known value whenever wr_en_i is high. The stimulus drives both inputs on the falling edge, so they are never unknown at a sampling edge. The kick-pulse and signature-clear properties also rely on the final value 16'h8888 being nonzero, which holds for the default offsets. The random stimulus mostly follows the correct loop order, so kicks occur often. It mixes in skipped steps, repeated steps, idle cycles and out-of-range codes, and it resets after a fault has been observed for a while, so that fault-free stretches keep coming back.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  typedef enum logic [1:0] {
    OP_SEED  = 2'd0,
    OP_ENTRY = 2'd1,
    OP_BODY  = 2'd2,
    OP_KICK  = 2'd3
  } op_e;
endpackage

// File: rtl/ckg_decode.sv
module ckg_decode
  import ckg_pkg::*;
#(
  parameter int unsigned       CODE_W     = 4,
  parameter logic [CODE_W-1:0] CODE_SEED  = 'h1,
  parameter logic [CODE_W-1:0] CODE_ENTRY = 'h2,
  parameter logic [CODE_W-1:0] CODE_BODY  = 'h3,
  parameter logic [CODE_W-1:0] CODE_KICK  = 'h4
) (
  input  logic              wr_en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              op_vld_o,
  output op_e               op_o,
  output logic              bad_o
);
  always_comb begin
    op_vld_o = 1'b0;
    op_o     = OP_SEED;
    bad_o    = 1'b0;
    if (wr_en_i) begin
      unique case (code_i)
        CODE_SEED:  begin op_vld_o = 1'b1; op_o = OP_SEED;  end
        CODE_ENTRY: begin op_vld_o = 1'b1; op_o = OP_ENTRY; end
        CODE_BODY:  begin op_vld_o = 1'b1; op_o = OP_BODY;  end
        CODE_KICK:  begin op_vld_o = 1'b1; op_o = OP_KICK;  end
        default:    bad_o = 1'b1;
      endcase
    end
  end

  always_comb begin
    AST_DECODE_EXCL: assert (!(op_vld_o && bad_o)); // R7
  end
endmodule

// File: rtl/ckg_sig.sv
module ckg_sig
  import ckg_pkg::*;
#(
  parameter int unsigned       SIG_W   = 16,
  parameter logic [SIG_W-1:0]  SEED    = 'h5555,
  parameter logic [SIG_W-1:0]  STEP_A  = 'h1111,
  parameter logic [SIG_W-1:0]  STEP_B  = 'h2222
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  op_e              op_i,
  output logic [SIG_W-1:0] sig_o,
  output logic             entry_ok_o,
  output logic             final_ok_o
);
  localparam logic [SIG_W-1:0] FINAL = SEED + STEP_A + STEP_B;

  logic [SIG_W-1:0] sig_q, sig_d;

  assign entry_ok_o = (sig_q == SEED);
  assign final_ok_o = (sig_q == FINAL);
  assign sig_o      = sig_q;

  always_comb begin
    sig_d = sig_q;
    if (act_i) begin
      unique case (op_i)
        OP_SEED:  sig_d = SEED;
        OP_ENTRY: if (entry_ok_o) sig_d = sig_q + STEP_A;
        OP_BODY:  sig_d = sig_q + STEP_B;
        OP_KICK:  if (final_ok_o) sig_d = '0;
        default:  sig_d = sig_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= '0;
    else         sig_q <= sig_d;
  end

  AST_SEED_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i && op_i == OP_SEED |=> sig_q == SEED); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i |=> $stable(sig_q)); // R9
endmodule

// File: rtl/ckg_ctrl.sv
module ckg_ctrl
  import ckg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic op_vld_i,
  input  op_e  op_i,
  input  logic bad_i,
  input  logic entry_ok_i,
  input  logic final_ok_i,
  output logic kick_o,
  output logic fault_o
);
  logic fault_q, kick_q, trip;

  always_comb begin
    trip = bad_i;
    if (op_vld_i && op_i == OP_ENTRY && !entry_ok_i) trip = 1'b1;
    if (op_vld_i && op_i == OP_KICK  && !final_ok_i) trip = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      kick_q  <= 1'b0;
    end else begin
      fault_q <= fault_q | trip;
      kick_q  <= !fault_q && op_vld_i && op_i == OP_KICK && final_ok_i;
    end
  end

  assign kick_o  = kick_q;
  assign fault_o = fault_q;

  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q |=> fault_q); // R8
  AST_NO_KICK_FAULTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q |=> !kick_q); // R8
  AST_BAD_TRIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_i |=> fault_q); // R7
endmodule

// File: rtl/ckg_top.sv
module ckg_top
  import ckg_pkg::*;
#(
  parameter int unsigned       CODE_W     = 4,
  parameter int unsigned       SIG_W      = 16,
  parameter logic [SIG_W-1:0]  SEED       = 'h5555,
  parameter logic [SIG_W-1:0]  STEP_A     = 'h1111,
  parameter logic [SIG_W-1:0]  STEP_B     = 'h2222,
  parameter logic [CODE_W-1:0] CODE_SEED  = 'h1,
  parameter logic [CODE_W-1:0] CODE_ENTRY = 'h2,
  parameter logic [CODE_W-1:0] CODE_BODY  = 'h3,
  parameter logic [CODE_W-1:0] CODE_KICK  = 'h4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CODE_W-1:0] wr_code_i,
  output logic              kick_o,
  output logic              fault_o,
  output logic [SIG_W-1:0]  sig_o
);
  logic op_vld, bad, entry_ok, final_ok;
  op_e  op;

  ckg_decode #(
    .CODE_W(CODE_W), .CODE_SEED(CODE_SEED), .CODE_ENTRY(CODE_ENTRY),
    .CODE_BODY(CODE_BODY), .CODE_KICK(CODE_KICK)
  ) i_decode (
    .wr_en_i (wr_en_i),
    .code_i  (wr_code_i),
    .op_vld_o(op_vld),
    .op_o    (op),
    .bad_o   (bad)
  );

  // a raised fault freezes the signature as a debug breadcrumb
  ckg_sig #(
    .SIG_W(SIG_W), .SEED(SEED), .STEP_A(STEP_A), .STEP_B(STEP_B)
  ) i_sig (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (op_vld && !fault_o),
    .op_i      (op),
    .sig_o     (sig_o),
    .entry_ok_o(entry_ok),
    .final_ok_o(final_ok)
  );

  ckg_ctrl i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_vld_i  (op_vld),
    .op_i      (op),
    .bad_i     (bad),
    .entry_ok_i(entry_ok),
    .final_ok_i(final_ok),
    .kick_o    (kick_o),
    .fault_o   (fault_o)
  );

  AST_KICK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_o |-> sig_o == '0); // R5
  AST_KICK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_o |=> !kick_o); // R5
  AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> $stable(sig_o)); // R8
  AST_KICK_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> !kick_o); // R6
endmodule

// File: tb/test_ckg_top.sv
`timescale 1ns/1ps
module test_ckg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_code = 4'h0;
  logic        kick, fault;
  logic [15:0] sig;

  int unsigned n_vec = 0, n_bad = 0, cyc = 0;
  logic [15:0] e_sig = 16'h0;
  logic        e_fault = 1'b0, e_kick = 1'b0;
  int          fault_age = 0;

  always #4 clk = ~clk;

  ckg_top i_ckg_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_code_i(wr_code),
    .kick_o(kick), .fault_o(fault), .sig_o(sig)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, act=%0d exp<100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  function automatic string tag_of(logic en, logic [3:0] c);
    if (!en) return "R9";
    case (c)
      4'h1: return "R2";
      4'h2: return "R3";
      4'h3: return "R4";
      4'h4: return "R5/R6";
      default: return "R7";
    endcase
  endfunction

  // reference model step, from the requirements
  task automatic model(input logic en, input logic [3:0] c);
    e_kick = 1'b0;
    if (!en) return;
    if (e_fault) begin
      if (c > 4'h4 || c == 4'h0) e_fault = 1'b1;
      return;
    end
    case (c)
      4'h1: e_sig = 16'h5555;
      4'h2: if (e_sig == 16'h5555) e_sig = e_sig + 16'h1111; else e_fault = 1'b1;
      4'h3: e_sig = e_sig + 16'h2222;
      4'h4: if (e_sig == 16'h8888) begin e_sig = 16'h0; e_kick = 1'b1; end
            else e_fault = 1'b1;
      default: e_fault = 1'b1;
    endcase
  endtask

  task automatic check(input string tag);
    n_vec = n_vec + 1;
    if (sig !== e_sig || kick !== e_kick || fault !== e_fault) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: act sig=%h kick=%b fault=%b exp sig=%h kick=%b fault=%b",
               tag, sig, kick, fault, e_sig, e_kick, e_fault);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    e_sig = 16'h0; e_fault = 1'b0; e_kick = 1'b0; fault_age = 0;
    @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
  endtask

  // drive at negedge, check at the following negedge
  task automatic wr(input logic en, input logic [3:0] c);
    wr_en = en; wr_code = c;
    model(en, c);
    @(negedge clk);
    wr_en = 1'b0;
    check(tag_of(en, c));
  endtask

  initial begin
    int step;
    logic [3:0] seq [4];
    seq[0] = 4'h1; seq[1] = 4'h2; seq[2] = 4'h3; seq[3] = 4'h4;
    void'($urandom(32'd1234));
    do_reset();

    // directed: clean loop twice, R2 R3 R4 R5
    for (int k = 0; k < 2; k++) begin
      wr(1, 4'h1); wr(1, 4'h2); wr(1, 4'h3); wr(1, 4'h4); wr(0, 4'h0);
    end
    // direct jump to kick (R6), then sticky and frozen (R8)
    wr(1, 4'h4); wr(1, 4'h1); wr(1, 4'h3); wr(0, 4'h0);
    do_reset();
    // entry checkpoint without seed (R3 fault)
    wr(1, 4'h2); do_reset();
    // body skipped (R6), body repeated (R6)
    wr(1, 4'h1); wr(1, 4'h2); wr(1, 4'h4); do_reset();
    wr(1, 4'h1); wr(1, 4'h2); wr(1, 4'h3); wr(1, 4'h3); wr(1, 4'h4); do_reset();
    // unknown codes (R7)
    wr(1, 4'h0); do_reset();
    wr(1, 4'hF); wr(1, 4'h1); wr(1, 4'h4); do_reset();
    // body wraps modulo 2^16 (R4)
    for (int k = 0; k < 9; k++) wr(1, 4'h3);
    do_reset();

    // random mix
    step = 0;
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 99));
      if (r < 15) wr(0, 4'h0);
      else if (r < 88) begin
        wr(1, seq[step]); step = (step + 1) % 4;
      end else wr(1, 4'($urandom_range(0, 15)));
      if (e_fault) begin
        fault_age++;
        if (fault_age > 4) begin do_reset(); step = 0; end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule